// File: doc/BRIEF.md
# Write-Protect Command Sequence Guard

This block sits between the bus side of a byte-wide nonvolatile memory and its page-write sequencer. It watches each committed write (address and data). It recognises two fixed multi-write commands: a three-write command that turns protection on, and a six-write command that turns it off. It also decides which writes are forwarded to the sequencer. A sticky protection flag is kept in a register. That register loads a power-up value from an input during reset, which stands in for the nonvolatile cell.

With protection off, ordinary writes are forwarded after one cycle and keep their order. Writes that match the opening steps of a command are held back in a small queue. If the sequence completes, they are dropped. If the sequence breaks, they are released in their original order, followed by the write that broke it. With protection on, only a completed lock command opens a page window. In that window every write is forwarded until the page-write logic signals that the page load is finished, and then the block locks again. A completed unlock command keeps the flag set until the page-write logic signals that the write cycle time has elapsed.

The command matcher has the states M_IDLE, M_K1, M_K2, M_PRE, M_PK1 and M_PK2:
- M_IDLE goes to M_K1 on AA written to 5555.
- M_K1 goes to M_K2 on 55 written to 2AAA.
- M_K2 either completes the lock command on A0 written to 5555, or goes to M_PRE on 80 written to 5555.
- M_PRE goes to M_PK1 on AA written to 5555.
- M_PK1 goes to M_PK2 on 55 written to 2AAA.
- M_PK2 completes the unlock command on 20 written to 5555.
- Any other write in a non-idle state is a break and returns the matcher to M_IDLE.

The lock controller has the states L_OPEN, L_LOCKED, L_WINDOW and L_UNLOCKING:
- L_OPEN and L_LOCKED go to L_WINDOW on a lock hit, and to L_UNLOCKING on an unlock hit.
- L_WINDOW goes to L_LOCKED on page_done.
- L_UNLOCKING goes to L_OPEN on wc_done.

Top module: `wp_seq_guard`

## Requirements
- R1: While rst_n is low at a clock edge, prot_on takes the value of nv_prot_init, the queue empties, fwd_valid is 0 and cmd_strobe is 0.
- R2: The lock command is the write sequence AA@5555, 55@2AAA, A0@5555 (hex data@address). Only address bits 14..0 are compared, so bit 15 is ignored. The cycle after the completing write, cmd_strobe is 1 for one cycle with cmd_is_unlock 0, and prot_on is 1.
- R3: The unlock command is AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555, with the same address rule. The cycle after the completing write, cmd_strobe is 1 with cmd_is_unlock 1. prot_on stays 1 until the edge at which wc_done is sampled high, and reads 0 from the following cycle.
- R4: No write that belongs to a completed command is ever forwarded.
- R5: After a lock command, every write is forwarded in order, including one given in the same cycle as page_done. From the edge at which page_done is seen, the block is locked.
- R6: While locked, ordinary writes, command prefixes and the writes that break them are all discarded. Commands are still recognised.
- R7: While unprotected, a write that does not start a command is forwarded. It is visible on fwd_valid/fwd_addr/fwd_data the cycle after its edge, in arrival order.
- R8: While unprotected, command prefix writes are held. A break releases them, followed by the breaking write, one per cycle in arrival order. The breaking write is not re-examined as the start of a new command.
- R9: Between an unlock command and wc_done, every write is discarded, including a write in the wc_done cycle.
- R10: The release queue never overflows, and every write forwarded by the guard leaves it exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nv_prot_init | input | 1 | Stored protection value loaded during reset |
| wr_valid | input | 1 | A committed write is present this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| page_done | input | 1 | Page load finished (from page-write logic) |
| wc_done | input | 1 | Write cycle time elapsed (from page-write logic) |
| fwd_valid | output | 1 | Forwarded write to the page-write sequencer |
| fwd_addr | output | ADDR_W | Address of the forwarded write |
| fwd_data | output | DATA_W | Data of the forwarded write |
| cmd_strobe | output | 1 | One-cycle mark of a completed, suppressed command |
| cmd_is_unlock | output | 1 | Kind of command marked: 1 unlock, 0 lock |
| prot_on | output | 1 | Sticky protection flag |

## Verification
Two pairs of events can fall in the same cycle, and the bench drives each pair together.

The first pair is a write arriving in the same cycle as page_done while the page window is open. That write must still be forwarded, and the block must then be locked, so later writes are discarded.

The second pair is a write arriving in the same cycle as wc_done during unlocking. That write must be dropped, and prot_on must fall on the next cycle.

Release bursts from a break also overlap with newly held prefix writes. Forwarded order and count are judged against a bench model queue, cycle by cycle.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;
    // compared widths of a command write
    localparam int CMD_AW = 15;
    localparam int CMD_DW = 8;

    localparam logic [CMD_AW-1:0] CMD_ADDR_A = 15'h5555;
    localparam logic [CMD_AW-1:0] CMD_ADDR_B = 15'h2AAA;

    localparam logic [CMD_DW-1:0] KEY_FIRST  = 8'hAA;
    localparam logic [CMD_DW-1:0] KEY_SECOND = 8'h55;
    localparam logic [CMD_DW-1:0] KEY_LOCK   = 8'hA0;
    localparam logic [CMD_DW-1:0] KEY_PRE    = 8'h80;
    localparam logic [CMD_DW-1:0] KEY_UNLOCK = 8'h20;

    typedef enum logic [2:0] {
        M_IDLE,
        M_K1,
        M_K2,
        M_PRE,
        M_PK1,
        M_PK2
    } match_t;

    typedef enum logic [1:0] {
        L_OPEN,
        L_LOCKED,
        L_WINDOW,
        L_UNLOCKING
    } lock_t;
endpackage

// File: rtl/wp_cmd_match.sv
module wp_cmd_match
    import wp_guard_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wr_valid,
    input  logic [CMD_AW-1:0] key_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              adv,
    output logic              hit_lock,
    output logic              hit_unlock,
    output logic              brk,
    output logic              plain
);
    match_t st, st_nx;
    logic   hi_zero, at_a, at_b;
    logic   d_first, d_second, d_lock, d_pre, d_unlock;

    always_comb begin
        hi_zero  = (wr_data >> CMD_DW) == '0;
        at_a     = key_addr == CMD_ADDR_A;
        at_b     = key_addr == CMD_ADDR_B;
        d_first  = hi_zero && (wr_data[CMD_DW-1:0] == KEY_FIRST);
        d_second = hi_zero && (wr_data[CMD_DW-1:0] == KEY_SECOND);
        d_lock   = hi_zero && (wr_data[CMD_DW-1:0] == KEY_LOCK);
        d_pre    = hi_zero && (wr_data[CMD_DW-1:0] == KEY_PRE);
        d_unlock = hi_zero && (wr_data[CMD_DW-1:0] == KEY_UNLOCK);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= M_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx      = st;
        adv        = 1'b0;
        hit_lock   = 1'b0;
        hit_unlock = 1'b0;
        brk        = 1'b0;
        plain      = 1'b0;
        if (!run) begin
            st_nx = M_IDLE;
        end else if (wr_valid) begin
            unique case (st)
                M_IDLE: begin
                    if (at_a && d_first) begin st_nx = M_K1; adv = 1'b1; end
                    else plain = 1'b1;
                end
                M_K1:  if (at_b && d_second) begin st_nx = M_K2; adv = 1'b1; end
                M_K2: begin
                    if (at_a && d_lock) begin hit_lock = 1'b1; st_nx = M_IDLE; end
                    else if (at_a && d_pre) begin st_nx = M_PRE; adv = 1'b1; end
                end
                M_PRE: if (at_a && d_first) begin st_nx = M_PK1; adv = 1'b1; end
                M_PK1: if (at_b && d_second) begin st_nx = M_PK2; adv = 1'b1; end
                M_PK2: if (at_a && d_unlock) begin hit_unlock = 1'b1; st_nx = M_IDLE; end
                default: st_nx = M_IDLE;
            endcase
            if (st != M_IDLE && !adv && !hit_lock && !hit_unlock) begin
                brk   = 1'b1;
                st_nx = M_IDLE;
            end
        end
    end

    a_r8_break_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        brk |=> st == M_IDLE);
    a_r2_hit_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_lock || hit_unlock) |=> st == M_IDLE);
    a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wr_valid) |-> $countones({adv, hit_lock, hit_unlock, brk, plain}) == 1);
endmodule

// File: rtl/wp_hold_fifo.sv
module wp_hold_fifo #(
    parameter int W     = 24,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         push_rel,
    input  logic         rel_all,
    input  logic         drop_held,
    input  logic [W-1:0] din,
    output logic         out_valid,
    output logic [W-1:0] dout
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] head, tail;
    logic [CW-1:0] cnt, rel, held, cnt_n, rel_n;
    logic          pop;

    always_comb begin
        held      = cnt - rel;
        pop       = rel != '0;
        out_valid = pop;
        dout      = mem[head];
        cnt_n     = cnt;
        rel_n     = rel;
        if (pop) begin
            cnt_n = cnt_n - CW'(1);
            rel_n = rel_n - CW'(1);
        end
        if (drop_held) cnt_n = cnt_n - held;
        if (push)      cnt_n = cnt_n + CW'(1);
        if (rel_all)             rel_n = rel_n + held + CW'(push);
        else if (push && push_rel) rel_n = rel_n + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            tail <= '0;
            cnt  <= '0;
            rel  <= '0;
        end else begin
            head <= head + PW'(pop);
            if (drop_held)  tail <= tail - held[PW-1:0];
            else if (push)  tail <= tail + PW'(1);
            cnt <= cnt_n;
            rel <= rel_n;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !drop_held) mem[tail] <= din;
    end

    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (int'(cnt) < DEPTH) || pop);
    a_r10_release_within: assert property (@(posedge clk) disable iff (!rst_n)
        rel <= cnt);
    a_r4_drop_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        drop_held |-> !push);
    a_r10_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !push && !rel_all) |=> rel == $past(rel) - CW'(1));
endmodule

// File: rtl/wp_lock_ctrl.sv
module wp_lock_ctrl
    import wp_guard_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  nv_prot_init,
    input  logic  hit_lock,
    input  logic  hit_unlock,
    input  logic  page_done,
    input  logic  wc_done,
    output lock_t st,
    output logic  cmd_strobe,
    output logic  cmd_is_unlock,
    output logic  prot_on
);
    lock_t st_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st            <= nv_prot_init ? L_LOCKED : L_OPEN;
            cmd_strobe    <= 1'b0;
            cmd_is_unlock <= 1'b0;
        end else begin
            st            <= st_nx;
            cmd_strobe    <= hit_lock || hit_unlock;
            cmd_is_unlock <= hit_unlock;
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            L_OPEN, L_LOCKED: begin
                if (hit_lock)        st_nx = L_WINDOW;
                else if (hit_unlock) st_nx = L_UNLOCKING;
            end
            L_WINDOW:    if (page_done) st_nx = L_LOCKED;
            L_UNLOCKING: if (wc_done)   st_nx = L_OPEN;
            default:     st_nx = L_LOCKED;
        endcase
    end

    always_comb prot_on = (st != L_OPEN);

    a_r2_lock_opens_window: assert property (@(posedge clk) disable iff (!rst_n)
        hit_lock |=> (st == L_WINDOW) && cmd_strobe && !cmd_is_unlock);
    a_r3_unlock_waits: assert property (@(posedge clk) disable iff (!rst_n)
        hit_unlock |=> (st == L_UNLOCKING) && cmd_strobe && cmd_is_unlock);
    a_r3_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st == L_UNLOCKING && !wc_done) |=> prot_on);
    a_r5_page_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (st == L_WINDOW && page_done) |=> st == L_LOCKED);
endmodule

// File: rtl/wp_seq_guard.sv
module wp_seq_guard
    import wp_guard_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int HOLD_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nv_prot_init,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              page_done,
    input  logic              wc_done,
    output logic              fwd_valid,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [DATA_W-1:0] fwd_data,
    output logic              cmd_strobe,
    output logic              cmd_is_unlock,
    output logic              prot_on
);
    localparam int ENT_W = ADDR_W + DATA_W;

    lock_t            st;
    logic             run, adv, hit_lock, hit_unlock, brk, plain;
    logic             is_open, is_win;
    logic             push, push_rel, rel_all, drop_held;
    logic [ENT_W-1:0] dout;

    always_comb begin
        is_open   = st == L_OPEN;
        is_win    = st == L_WINDOW;
        run       = is_open || st == L_LOCKED;
        push      = wr_valid && (is_win || (is_open && (adv || brk || plain)));
        push_rel  = is_win || plain;
        rel_all   = is_open && brk;
        drop_held = is_open && (hit_lock || hit_unlock);
    end

    wp_cmd_match #(.DATA_W(DATA_W)) match_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .wr_valid   (wr_valid),
        .key_addr   (wr_addr[CMD_AW-1:0]),
        .wr_data    (wr_data),
        .adv        (adv),
        .hit_lock   (hit_lock),
        .hit_unlock (hit_unlock),
        .brk        (brk),
        .plain      (plain)
    );

    wp_lock_ctrl lock_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .nv_prot_init  (nv_prot_init),
        .hit_lock      (hit_lock),
        .hit_unlock    (hit_unlock),
        .page_done     (page_done),
        .wc_done       (wc_done),
        .st            (st),
        .cmd_strobe    (cmd_strobe),
        .cmd_is_unlock (cmd_is_unlock),
        .prot_on       (prot_on)
    );

    wp_hold_fifo #(.W(ENT_W), .DEPTH(HOLD_DEPTH)) hold_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_rel  (push_rel),
        .rel_all   (rel_all),
        .drop_held (drop_held),
        .din       ({wr_addr, wr_data}),
        .out_valid (fwd_valid),
        .dout      (dout)
    );

    always_comb begin
        fwd_addr = dout[ENT_W-1:DATA_W];
        fwd_data = dout[DATA_W-1:0];
    end

    a_r6_locked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (st == L_LOCKED) |-> !push);
    a_r9_unlocking_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (st == L_UNLOCKING) |-> !push);
    a_r4_cmd_not_queued: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_lock || hit_unlock) |-> !push);
endmodule

// File: tb/wp_seq_guard_tb_top.sv
`timescale 1ns/1ps
module wp_seq_guard_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nv_prot_init = 1'b0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        page_done = 1'b0;
    logic        wc_done = 1'b0;
    logic        fwd_valid, cmd_strobe, cmd_is_unlock, prot_on;
    logic [15:0] fwd_addr;
    logic [7:0]  fwd_data;

    always #2.5 clk = ~clk;

    wp_seq_guard dut_i (
        .clk(clk), .rst_n(rst_n), .nv_prot_init(nv_prot_init),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .page_done(page_done), .wc_done(wc_done),
        .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_data(fwd_data),
        .cmd_strobe(cmd_strobe), .cmd_is_unlock(cmd_is_unlock), .prot_on(prot_on)
    );

    int          n_chk = 0, n_fail = 0, fwd_seen = 0, snap = 0;
    bit          mon_en = 1'b0;
    logic [23:0] exp_q[$];
    logic [23:0] held_q[$];
    int          mst = 0;   // 0 open, 1 locked, 2 window, 3 unlocking
    int          mstep = 0;
    bit          exp_cmd = 1'b0, exp_kind = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic bit adv_ok(input int step, input logic [14:0] k, input logic [7:0] d);
        case (step)
            0: return d == 8'hAA && k == 15'h5555;
            1: return d == 8'h55 && k == 15'h2AAA;
            2: return d == 8'h80 && k == 15'h5555;
            3: return d == 8'hAA && k == 15'h5555;
            4: return d == 8'h55 && k == 15'h2AAA;
            default: return 1'b0;
        endcase
    endfunction

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        logic [23:0] e;
        logic [14:0] k;
        e = {a, d};
        k = a[14:0];
        exp_cmd  = 1'b0;
        exp_kind = 1'b0;
        if (mst == 2) begin exp_q.push_back(e); return; end
        if (mst == 3) return;
        if (mstep == 2 && d == 8'hA0 && k == 15'h5555) begin
            exp_cmd = 1'b1; held_q.delete(); mstep = 0; mst = 2;
        end else if (mstep == 5 && d == 8'h20 && k == 15'h5555) begin
            exp_cmd = 1'b1; exp_kind = 1'b1; held_q.delete(); mstep = 0; mst = 3;
        end else if (adv_ok(mstep, k, d)) begin
            mstep++;
            if (mst == 0) held_q.push_back(e);
        end else if (mstep != 0) begin
            if (mst == 0) begin
                foreach (held_q[i]) exp_q.push_back(held_q[i]);
                exp_q.push_back(e);
            end
            held_q.delete();
            mstep = 0;
        end else if (mst == 0) begin
            exp_q.push_back(e);
        end
    endtask

    // forwarded stream checked against the model queue
    always @(negedge clk) begin
        if (mon_en && fwd_valid) begin
            fwd_seen++;
            if (exp_q.size() == 0)
                check(1'b0, "R7", "unexpected forward", int'({fwd_addr, fwd_data}), 0);
            else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                check({fwd_addr, fwd_data} == e, "R7", "forward order/content",
                      int'({fwd_addr, fwd_data}), int'(e));
            end
        end
    end

    task automatic post_checks();
        check(cmd_strobe == exp_cmd, exp_kind ? "R3" : "R2", "cmd_strobe", cmd_strobe, exp_cmd);
        if (exp_cmd)
            check(cmd_is_unlock == exp_kind, "R3", "cmd_is_unlock", cmd_is_unlock, exp_kind);
        check(prot_on == (mst != 0), "R3", "prot_on", prot_on, (mst != 0));
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        model_write(a, d);
        @(negedge clk);
        wr_valid = 1'b0;
        post_checks();
    endtask

    task automatic pulse(input bit pg, input bit wc, input bit with_wr,
                         input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        page_done = pg; wc_done = wc;
        exp_cmd = 1'b0; exp_kind = 1'b0;
        if (with_wr) begin
            wr_valid = 1'b1; wr_addr = a; wr_data = d;
            model_write(a, d);
        end
        if (pg && mst == 2) mst = 1;
        if (wc && mst == 3) mst = 0;
        @(negedge clk);
        page_done = 1'b0; wc_done = 1'b0; wr_valid = 1'b0;
        post_checks();
    endtask

    task automatic settle();
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R10", "pending forwards", exp_q.size(), 0);
    endtask

    task automatic do_reset(input bit nv);
        settle();
        mon_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b0; nv_prot_init = nv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mst = nv ? 1 : 0; mstep = 0;
        held_q.delete(); exp_q.delete();
        check(prot_on == nv, "R1", "prot_on after reset", prot_on, nv);
        check(fwd_valid == 1'b0, "R1", "fwd_valid after reset", fwd_valid, 0);
        check(cmd_strobe == 1'b0, "R1", "cmd_strobe after reset", cmd_strobe, 0);
        mon_en = 1'b1;
    endtask

    task automatic lock_cmd(input bit b15);
        wr({b15, 15'h5555}, 8'hAA);
        wr(16'h2AAA, 8'h55);
        wr(16'h5555, 8'hA0);
    endtask

    task automatic unlock_cmd();
        wr(16'h5555, 8'hAA); wr(16'hAAAA, 8'h55); wr(16'h5555, 8'h80);
        wr(16'hD555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h20);
    endtask

    task automatic expect_fwd(input string req, input int n);
        settle();
        check(fwd_seen - snap == n, req, "forward count", fwd_seen - snap, n);
        snap = fwd_seen;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        do_reset(1'b0);
        snap = fwd_seen;
        // R7 plain writes
        wr(16'h1234, 8'h11); wr(16'h0042, 8'h22); wr(16'hFFFF, 8'h5A);
        expect_fwd("R7", 3);
        // R2/R4 lock command with bit 15 set on first write
        lock_cmd(1'b1);
        expect_fwd("R4", 0);
        // R5 window, write in the page_done cycle
        wr(16'h0100, 8'h01); wr(16'h0101, 8'h02); wr(16'h5555, 8'hAA);
        pulse(1'b1, 1'b0, 1'b1, 16'h0103, 8'h04);
        expect_fwd("R5", 4);
        // R6 locked discards
        wr(16'h0200, 8'h33); wr(16'h5555, 8'hAA); wr(16'h0001, 8'h12);
        expect_fwd("R6", 0);
        lock_cmd(1'b0);
        pulse(1'b1, 1'b0, 1'b0, 16'h0, 8'h0);
        // R3 unlock from locked, R9 writes dropped while waiting
        unlock_cmd();
        wr(16'h0300, 8'h44);
        pulse(1'b0, 1'b1, 1'b1, 16'h0301, 8'h45);
        expect_fwd("R9", 0);
        check(prot_on == 1'b0, "R3", "prot_on after wc_done", prot_on, 0);
        // R8 break releases held writes
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h0100, 8'h77);
        expect_fwd("R8", 3);
        wr(16'h5555, 8'hAA); wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55);
        expect_fwd("R8", 3);
        // R3 unlock while already open
        unlock_cmd();
        pulse(1'b0, 1'b1, 1'b0, 16'h0, 8'h0);
        expect_fwd("R4", 0);

        // random phase
        void'($urandom(32'd24681357));
        for (int i = 0; i < 600; i++) begin
            int r;
            logic [15:0] a;
            logic [7:0]  d;
            r = $urandom_range(0, 99);
            case ($urandom_range(0, 5))
                0: d = 8'hAA; 1: d = 8'h55; 2: d = 8'hA0;
                3: d = 8'h80; 4: d = 8'h20; default: d = 8'($urandom);
            endcase
            case ($urandom_range(0, 2))
                0: a = 16'h5555; 1: a = 16'h2AAA; default: a = 16'($urandom);
            endcase
            a[15] = 1'($urandom);
            if (r < 8)       lock_cmd(1'($urandom));
            else if (r < 12) unlock_cmd();
            else if (r < 20) pulse(1'b1, 1'b0, 1'($urandom), a, d);
            else if (r < 27) pulse(1'b0, 1'b1, 1'($urandom), a, d);
            else             wr(a, d);
        end
        settle();

        // R1 stored flag set at power-up; R6 locked discards
        do_reset(1'b1);
        snap = fwd_seen;
        wr(16'h0400, 8'h55); wr(16'h0401, 8'h66);
        expect_fwd("R6", 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R10 actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule